// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block tracks every micro-op that has been issued but not yet committed. It is a ring of entries. Up to four micro-ops are placed at the tail each cycle, in program order. Each new micro-op receives the index of its entry, and that index is the physical register name later stages use to refer to its result. Two writeback ports can mark any occupied entry complete, in any order. A writeback carries the 32-bit result and two flags: one for a mispredicted branch and one for a fault.

Each cycle, retirement looks at up to three entries starting at the head, oldest first. It stops at the first entry that has not completed. Each retired entry writes its result into a small committed register file, which has a combinational read port. Recovery happens only at this point:

- A mispredicted branch retires normally, and every younger entry is discarded.
- A faulting micro-op is discarded without committing, together with everything younger.

In both cases the ring empties and the next allocation starts right behind the last committed entry.

Top module: `rob_core`

## Requirements
- R1: After reset the occupancy is 0, no retirement or flush is signalled, allocation is not stalled, and every committed register reads 0.
- R2: A granted request of N micro-ops (alloc_cnt_i = N) assigns indices tail, tail+1, … to slots 0..N-1 of alloc_idx_o, wrapping from DEPTH-1 to 0. Occupancy rises by N on the next edge.
- R3: alloc_stall_o is high when alloc_cnt_i exceeds DEPTH minus the occupancy. A stalled request allocates nothing, and occupancy never exceeds DEPTH.
- R4: A writeback marks its target entry complete, in any order relative to other entries. A writeback to an unoccupied entry is ignored, so a micro-op allocated there later still waits for its own writeback.
- R5: Retirement takes entries only from the head, in order, at most RET_W (3) per cycle. It stops at the first incomplete entry, so complete entries behind it wait. ret_cnt_o gives the number retiring in the current cycle.
- R6: Each retired entry writes its result to its destination register. The new value is readable on arf_raddr_i/arf_rdata_o after the edge on which it retires. When several entries retiring together target the same register, the youngest value remains.
- R7: A complete entry flagged as a mispredicted branch retires and commits its value, and flush_o is high in that cycle. All younger entries are discarded, occupancy becomes 0, and the next allocation receives the index following the branch.
- R8: A complete entry flagged as faulting, when it reaches the retire window, commits nothing. flush_o and flush_exc_o are high in that cycle. The entry and all younger entries are discarded, and the next allocation receives that entry's index again. Older complete entries in the same window still retire.
- R9: An allocation request presented in a flush cycle is dropped even when it would not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_cnt_i | input | 3 | Number of micro-ops to allocate this cycle (0..4) |
| alloc_dst_i | input | 12 | Destination register per slot, 3 bits each, slot 0 in the low bits |
| alloc_stall_o | output | 1 | Request exceeds free entries; nothing allocated |
| alloc_idx_o | output | 24 | Entry index per slot, 6 bits each, slot 0 in the low bits |
| wb_valid_i | input | 2 | Writeback strobe per port |
| wb_idx_i | input | 12 | Target entry per port, 6 bits each |
| wb_data_i | input | 64 | Result per port, 32 bits each |
| wb_mispred_i | input | 2 | Branch mispredicted, per port |
| wb_exc_i | input | 2 | Micro-op faulted, per port |
| ret_cnt_o | output | 2 | Entries retiring this cycle |
| flush_o | output | 1 | Younger entries discarded at this edge |
| flush_exc_o | output | 1 | Flush caused by a fault |
| occ_o | output | 6 | Occupied entries |
| arf_raddr_i | input | 3 | Committed register read address |
| arf_rdata_o | output | 32 | Committed register read data |

## Verification
The properties assume the following about the inputs:
- alloc_cnt_i never exceeds four.
- Each writeback names an entry that is occupied, or one that is deliberately left empty.
- A given entry gets at most one writeback per cycle.

The directed scenarios keep to these rules. Every writeback index the bench drives is one it has just received on alloc_idx_o, apart from the single deliberate write to a free entry. Both ports never target the same entry in one cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_MISPRED = 2'd1,
    CAUSE_EXC     = 2'd2
  } flush_cause_e;

  // ring pointer advance, k never exceeds depth
  function automatic int unsigned ring_add(int unsigned p, int unsigned k, int unsigned depth);
    int unsigned s;
    s = p + k;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/rob_alloc.sv
module rob_alloc import rob_pkg::*; #(
  parameter int DEPTH   = 40,
  parameter int ALLOC_W = 4,
  parameter int IDX_W   = 6,
  parameter int OCC_W   = 6,
  parameter int CNT_W   = 3
) (
  input  logic [IDX_W-1:0]         tail_i,
  input  logic [OCC_W-1:0]         occ_i,
  input  logic [CNT_W-1:0]         alloc_cnt_i,
  input  logic                     flush_i,
  output logic                     stall_o,
  output logic [ALLOC_W-1:0]       slot_en_o,
  output logic [ALLOC_W*IDX_W-1:0] idx_o,
  output logic [CNT_W-1:0]         nalloc_o
);

  logic grant;

  assign stall_o  = int'(alloc_cnt_i) > (DEPTH - int'(occ_i));
  assign grant    = !stall_o && !flush_i;
  assign nalloc_o = grant ? alloc_cnt_i : '0;

  for (genvar k = 0; k < ALLOC_W; k++) begin : g_slot
    assign slot_en_o[k] = grant && (k < int'(alloc_cnt_i));
    assign idx_o[k*IDX_W +: IDX_W] = IDX_W'(ring_add(32'(tail_i), k, DEPTH));
  end

endmodule

// File: rtl/rob_retire.sv
module rob_retire import rob_pkg::*; #(
  parameter int DEPTH  = 40,
  parameter int RET_W  = 3,
  parameter int IDX_W  = 6,
  parameter int OCC_W  = 6,
  parameter int RCNT_W = 2
) (
  input  logic [IDX_W-1:0]       head_i,
  input  logic [OCC_W-1:0]       occ_i,
  input  logic [DEPTH-1:0]       done_i,
  input  logic [DEPTH-1:0]       mis_i,
  input  logic [DEPTH-1:0]       exc_i,
  output logic [RET_W-1:0]       ret_en_o,
  output logic [RET_W*IDX_W-1:0] ret_idx_o,
  output logic [RCNT_W-1:0]      ret_cnt_o,
  output flush_cause_e           cause_o
);

  // serial scan: an entry may retire only if every older slot in the window did
  always_comb begin
    logic             chain;
    logic [IDX_W-1:0] idx;
    int               cnt;
    chain     = 1'b1;
    cnt       = 0;
    ret_en_o  = '0;
    ret_idx_o = '0;
    cause_o   = CAUSE_NONE;
    for (int k = 0; k < RET_W; k++) begin
      idx = IDX_W'(ring_add(32'(head_i), unsigned'(k), DEPTH));
      if (chain && (k < int'(occ_i)) && done_i[idx]) begin
        if (exc_i[idx]) begin
          cause_o = CAUSE_EXC;
          chain   = 1'b0;
        end else begin
          ret_en_o[k]                  = 1'b1;
          ret_idx_o[k*IDX_W +: IDX_W]  = idx;
          cnt++;
          if (mis_i[idx]) begin
            cause_o = CAUSE_MISPRED;
            chain   = 1'b0;
          end
        end
      end else begin
        chain = 1'b0;
      end
    end
    ret_cnt_o = RCNT_W'(cnt);
  end

endmodule

// File: rtl/rob_arf.sv
module rob_arf #(
  parameter int AREG_N = 8,
  parameter int AREG_W = 3,
  parameter int DATA_W = 32,
  parameter int RET_W  = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [RET_W-1:0]          we_i,
  input  logic [RET_W*AREG_W-1:0]   waddr_i,
  input  logic [RET_W*DATA_W-1:0]   wdata_i,
  input  logic [AREG_W-1:0]         raddr_i,
  output logic [DATA_W-1:0]         rdata_o
);

  logic [DATA_W-1:0] regs_q [AREG_N];

  // ascending slot order: the youngest write to a register wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < AREG_N; i++) regs_q[i] <= '0;
    end else begin
      for (int k = 0; k < RET_W; k++) begin
        if (we_i[k]) regs_q[waddr_i[k*AREG_W +: AREG_W]] <= wdata_i[k*DATA_W +: DATA_W];
      end
    end
  end

  assign rdata_o = regs_q[raddr_i];

endmodule

// File: rtl/rob_core.sv
module rob_core import rob_pkg::*; #(
  parameter  int DEPTH   = 40,
  parameter  int ALLOC_W = 4,
  parameter  int RET_W   = 3,
  parameter  int WB_N    = 2,
  parameter  int DATA_W  = 32,
  parameter  int AREG_N  = 8,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int OCC_W   = $clog2(DEPTH + 1),
  localparam int CNT_W   = $clog2(ALLOC_W + 1),
  localparam int RCNT_W  = $clog2(RET_W + 1),
  localparam int AREG_W  = $clog2(AREG_N)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [CNT_W-1:0]          alloc_cnt_i,
  input  logic [ALLOC_W*AREG_W-1:0] alloc_dst_i,
  output logic                      alloc_stall_o,
  output logic [ALLOC_W*IDX_W-1:0]  alloc_idx_o,
  input  logic [WB_N-1:0]           wb_valid_i,
  input  logic [WB_N*IDX_W-1:0]     wb_idx_i,
  input  logic [WB_N*DATA_W-1:0]    wb_data_i,
  input  logic [WB_N-1:0]           wb_mispred_i,
  input  logic [WB_N-1:0]           wb_exc_i,
  output logic [RCNT_W-1:0]         ret_cnt_o,
  output logic                      flush_o,
  output logic                      flush_exc_o,
  output logic [OCC_W-1:0]          occ_o,
  input  logic [AREG_W-1:0]         arf_raddr_i,
  output logic [DATA_W-1:0]         arf_rdata_o
);

  logic [IDX_W-1:0]  head_q, tail_q;
  logic [OCC_W-1:0]  occ_q;
  logic [DEPTH-1:0]  valid_q, done_q, mis_q, exc_q;
  logic [AREG_W-1:0] dst_q [DEPTH];
  logic [DATA_W-1:0] val_q [DEPTH];

  logic [ALLOC_W-1:0]       slot_en;
  logic [CNT_W-1:0]         nalloc;
  logic [RET_W-1:0]         ret_en;
  logic [RET_W*IDX_W-1:0]   ret_idx_flat;
  flush_cause_e             cause;
  logic                     flush;

  logic [IDX_W-1:0]  aidx  [ALLOC_W];
  logic [IDX_W-1:0]  ridx  [RET_W];
  logic [IDX_W-1:0]  widx  [WB_N];
  logic [WB_N-1:0]   wb_hit;
  logic [RET_W*AREG_W-1:0] arf_waddr;
  logic [RET_W*DATA_W-1:0] arf_wdata;

  rob_alloc #(
    .DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .IDX_W(IDX_W), .OCC_W(OCC_W), .CNT_W(CNT_W)
  ) u_alloc (
    .tail_i      (tail_q),
    .occ_i       (occ_q),
    .alloc_cnt_i (alloc_cnt_i),
    .flush_i     (flush),
    .stall_o     (alloc_stall_o),
    .slot_en_o   (slot_en),
    .idx_o       (alloc_idx_o),
    .nalloc_o    (nalloc)
  );

  rob_retire #(
    .DEPTH(DEPTH), .RET_W(RET_W), .IDX_W(IDX_W), .OCC_W(OCC_W), .RCNT_W(RCNT_W)
  ) u_retire (
    .head_i    (head_q),
    .occ_i     (occ_q),
    .done_i    (done_q),
    .mis_i     (mis_q),
    .exc_i     (exc_q),
    .ret_en_o  (ret_en),
    .ret_idx_o (ret_idx_flat),
    .ret_cnt_o (ret_cnt_o),
    .cause_o   (cause)
  );

  assign flush       = (cause != CAUSE_NONE);
  assign flush_o     = flush;
  assign flush_exc_o = (cause == CAUSE_EXC);
  assign occ_o       = occ_q;

  for (genvar k = 0; k < ALLOC_W; k++) begin : g_aidx
    assign aidx[k] = alloc_idx_o[k*IDX_W +: IDX_W];
  end

  for (genvar k = 0; k < RET_W; k++) begin : g_ret
    assign ridx[k] = ret_idx_flat[k*IDX_W +: IDX_W];
    assign arf_waddr[k*AREG_W +: AREG_W] = dst_q[ridx[k]];
    assign arf_wdata[k*DATA_W +: DATA_W] = val_q[ridx[k]];
  end

  for (genvar p = 0; p < WB_N; p++) begin : g_wb
    assign widx[p]   = wb_idx_i[p*IDX_W +: IDX_W];
    assign wb_hit[p] = wb_valid_i[p] && !flush && (int'(widx[p]) < DEPTH) && valid_q[widx[p]];
  end

  // entry state flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      done_q  <= '0;
      mis_q   <= '0;
      exc_q   <= '0;
    end else begin
      for (int k = 0; k < RET_W; k++) begin
        if (ret_en[k]) valid_q[ridx[k]] <= 1'b0;
      end
      if (flush) valid_q <= '0;
      for (int k = 0; k < ALLOC_W; k++) begin
        if (slot_en[k]) begin
          valid_q[aidx[k]] <= 1'b1;
          done_q[aidx[k]]  <= 1'b0;
          mis_q[aidx[k]]   <= 1'b0;
          exc_q[aidx[k]]   <= 1'b0;
        end
      end
      for (int p = 0; p < WB_N; p++) begin
        if (wb_hit[p]) begin
          done_q[widx[p]] <= 1'b1;
          mis_q[widx[p]]  <= wb_mispred_i[p];
          exc_q[widx[p]]  <= wb_exc_i[p];
        end
      end
    end
  end

  // entry payload, no reset needed
  always_ff @(posedge clk_i) begin
    for (int k = 0; k < ALLOC_W; k++) begin
      if (slot_en[k]) dst_q[aidx[k]] <= alloc_dst_i[k*AREG_W +: AREG_W];
    end
    for (int p = 0; p < WB_N; p++) begin
      if (wb_hit[p]) val_q[widx[p]] <= wb_data_i[p*DATA_W +: DATA_W];
    end
  end

  // pointers and occupancy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= IDX_W'(ring_add(32'(head_q), 32'(ret_cnt_o), DEPTH));
      if (flush) begin
        tail_q <= IDX_W'(ring_add(32'(head_q), 32'(ret_cnt_o), DEPTH));
        occ_q  <= '0;
      end else begin
        tail_q <= IDX_W'(ring_add(32'(tail_q), 32'(nalloc), DEPTH));
        occ_q  <= occ_q - OCC_W'(ret_cnt_o) + OCC_W'(nalloc);
      end
    end
  end

  rob_arf #(
    .AREG_N(AREG_N), .AREG_W(AREG_W), .DATA_W(DATA_W), .RET_W(RET_W)
  ) u_arf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ret_en),
    .waddr_i (arf_waddr),
    .wdata_i (arf_wdata),
    .raddr_i (arf_raddr_i),
    .rdata_o (arf_rdata_o)
  );

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH  = 40,
  parameter int RET_W  = 3,
  parameter int OCC_W  = 6,
  parameter int RCNT_W = 2,
  parameter int CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OCC_W-1:0]  occ_o,
  input logic [RCNT_W-1:0] ret_cnt_o,
  input logic              flush_o,
  input logic              flush_exc_o,
  input logic              alloc_stall_o,
  input logic [CNT_W-1:0]  alloc_cnt_i
);

  // R3
  occ_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(occ_o) <= DEPTH);

  // R3
  stall_no_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_stall_o && (alloc_cnt_i != '0)) |=> (occ_o <= $past(occ_o)));

  // R5
  ret_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(ret_cnt_o) <= RET_W) && (int'(ret_cnt_o) <= int'(occ_o)));

  // R7
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (occ_o == '0));

  // R8
  exc_is_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_exc_o |-> flush_o);

endmodule

bind rob_core rob_core_chk #(
  .DEPTH(DEPTH), .RET_W(RET_W), .OCC_W(OCC_W), .RCNT_W(RCNT_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .occ_o         (occ_o),
  .ret_cnt_o     (ret_cnt_o),
  .flush_o       (flush_o),
  .flush_exc_o   (flush_exc_o),
  .alloc_stall_o (alloc_stall_o),
  .alloc_cnt_i   (alloc_cnt_i)
);

// File: tb/sim_rob_core.sv
module sim_rob_core;

  localparam int DEPTH = 40;
  localparam int IW    = 6;
  localparam int DW    = 32;
  localparam int AW    = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    alloc_cnt_i;
  logic [4*AW-1:0] alloc_dst_i;
  logic          alloc_stall_o;
  logic [4*IW-1:0] alloc_idx_o;
  logic [1:0]    wb_valid_i;
  logic [2*IW-1:0] wb_idx_i;
  logic [2*DW-1:0] wb_data_i;
  logic [1:0]    wb_mispred_i;
  logic [1:0]    wb_exc_i;
  logic [1:0]    ret_cnt_o;
  logic          flush_o;
  logic          flush_exc_o;
  logic [5:0]    occ_o;
  logic [AW-1:0] arf_raddr_i;
  logic [DW-1:0] arf_rdata_o;

  int n_cmp = 0;
  int n_mis = 0;

  always #5 clk_i = ~clk_i;

  rob_core u0 (
    .clk_i, .rst_ni, .alloc_cnt_i, .alloc_dst_i, .alloc_stall_o, .alloc_idx_o,
    .wb_valid_i, .wb_idx_i, .wb_data_i, .wb_mispred_i, .wb_exc_i,
    .ret_cnt_o, .flush_o, .flush_exc_o, .occ_o, .arf_raddr_i, .arf_rdata_o
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    alloc_cnt_i  = '0;
    alloc_dst_i  = '0;
    wb_valid_i   = '0;
    wb_idx_i     = '0;
    wb_data_i    = '0;
    wb_mispred_i = '0;
    wb_exc_i     = '0;
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
    clr();
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic alloc_req(input int n, input int d0, input int d1, input int d2, input int d3);
    alloc_cnt_i = 3'(n);
    alloc_dst_i = {AW'(d3), AW'(d2), AW'(d1), AW'(d0)};
  endtask

  task automatic wb(input int port, input int idx, input logic [31:0] val, input logic mis, input logic exc);
    wb_valid_i[port]          = 1'b1;
    wb_idx_i[port*IW +: IW]   = IW'(idx);
    wb_data_i[port*DW +: DW]  = val;
    wb_mispred_i[port]        = mis;
    wb_exc_i[port]            = exc;
  endtask

  task automatic rd_chk(input string req, input int r, input logic [31:0] exp);
    arf_raddr_i = AW'(r);
    #1;
    chk(req, $sformatf("arf r%0d", r), arf_rdata_o, exp);
  endtask

  function automatic logic [31:0] slot_idx(input int k);
    return 32'(alloc_idx_o[k*IW +: IW]);
  endfunction

  task automatic t_reset();
    settle();
    chk("R1", "occ", 32'(occ_o), 0);
    chk("R1", "ret_cnt", 32'(ret_cnt_o), 0);
    chk("R1", "flush", 32'(flush_o), 0);
    chk("R1", "stall", 32'(alloc_stall_o), 0);
    rd_chk("R1", 3, 0);
  endtask

  task automatic t_alloc_basic();
    alloc_req(3, 1, 2, 3, 0);
    settle();
    chk("R2", "stall", 32'(alloc_stall_o), 0);
    for (int k = 0; k < 3; k++) chk("R2", "slot idx", slot_idx(k), 32'(k));
    step();
    settle();
    chk("R2", "occ", 32'(occ_o), 3);
  endtask

  task automatic t_inorder();
    wb(0, 2, 32'h22, 0, 0);
    wb(1, 1, 32'h11, 0, 0);
    step();
    settle();
    chk("R5", "ret blocked by incomplete head", 32'(ret_cnt_o), 0);
    rd_chk("R5", 2, 0);
    wb(0, 0, 32'hA0, 0, 0);
    step();
    settle();
    chk("R5", "ret after head done", 32'(ret_cnt_o), 3);
    step();
    settle();
    chk("R5", "occ drained", 32'(occ_o), 0);
    rd_chk("R6", 1, 32'hA0);
    rd_chk("R6", 2, 32'h11);
    rd_chk("R6", 3, 32'h22);
  endtask

  task automatic t_limit();
    alloc_req(4, 5, 5, 5, 5);
    settle();
    chk("R2", "slot0 idx", slot_idx(0), 3);
    chk("R2", "slot3 idx", slot_idx(3), 6);
    step();
    wb(0, 4, 32'h104, 0, 0);
    wb(1, 5, 32'h105, 0, 0);
    step();
    wb(0, 6, 32'h106, 0, 0);
    wb(1, 3, 32'h103, 0, 0);
    settle();
    chk("R5", "head 3 not done", 32'(ret_cnt_o), 0);
    step();
    settle();
    chk("R5", "width limit", 32'(ret_cnt_o), 3);
    step();
    settle();
    chk("R5", "remaining", 32'(ret_cnt_o), 1);
    rd_chk("R6", 5, 32'h105);
    step();
    settle();
    rd_chk("R6", 5, 32'h106);
    chk("R5", "occ", 32'(occ_o), 0);
  endtask

  task automatic t_wb_ignored();
    wb(1, 7, 32'hDEAD, 0, 0);
    step();
    alloc_req(1, 4, 0, 0, 0);
    settle();
    chk("R4", "idx", slot_idx(0), 7);
    step();
    settle();
    chk("R4", "stale write ignored", 32'(ret_cnt_o), 0);
    chk("R4", "occ", 32'(occ_o), 1);
    wb(0, 7, 32'h77, 0, 0);
    step();
    settle();
    chk("R4", "ret after real wb", 32'(ret_cnt_o), 1);
    step();
    settle();
    rd_chk("R4", 4, 32'h77);
  endtask

  task automatic t_fill_stall();
    for (int i = 0; i < 10; i++) begin
      alloc_req(4, 6, 6, 6, 6);
      settle();
      chk("R3", "no stall while filling", 32'(alloc_stall_o), 0);
      for (int k = 0; k < 4; k++) chk("R2", "wrap idx", slot_idx(k), 32'((8 + 4*i + k) % DEPTH));
      step();
    end
    settle();
    chk("R3", "full", 32'(occ_o), 40);
    alloc_req(1, 6, 0, 0, 0);
    settle();
    chk("R3", "stall when full", 32'(alloc_stall_o), 1);
    step();
    settle();
    chk("R3", "occ held", 32'(occ_o), 40);
  endtask

  task automatic t_mispred();
    wb(0, 8, 32'hB8, 1, 0);
    wb(1, 9, 32'h99, 0, 0);
    step();
    settle();
    chk("R7", "branch retires", 32'(ret_cnt_o), 1);
    chk("R7", "flush", 32'(flush_o), 1);
    chk("R7", "not exc", 32'(flush_exc_o), 0);
    step();
    settle();
    chk("R7", "occ after flush", 32'(occ_o), 0);
    rd_chk("R7", 6, 32'hB8);
    alloc_req(2, 7, 7, 0, 0);
    settle();
    chk("R7", "next idx after branch", slot_idx(0), 9);
    step();
  endtask

  task automatic t_flush_drop();
    wb(0, 9, 32'hC9, 1, 0);
    step();
    alloc_req(1, 7, 0, 0, 0);
    settle();
    chk("R9", "flush", 32'(flush_o), 1);
    chk("R9", "no stall", 32'(alloc_stall_o), 0);
    step();
    settle();
    chk("R9", "alloc dropped occ", 32'(occ_o), 0);
    alloc_req(1, 7, 0, 0, 0);
    settle();
    chk("R9", "idx reused", slot_idx(0), 10);
    step();
  endtask

  task automatic t_exception();
    wb(0, 10, 32'hEE, 0, 1);
    step();
    settle();
    chk("R8", "ret", 32'(ret_cnt_o), 0);
    chk("R8", "flush", 32'(flush_o), 1);
    chk("R8", "exc", 32'(flush_exc_o), 1);
    step();
    settle();
    chk("R8", "occ", 32'(occ_o), 0);
    rd_chk("R8", 7, 32'hC9);
    alloc_req(2, 3, 4, 0, 0);
    settle();
    chk("R8", "idx reused", slot_idx(0), 10);
    step();
    wb(0, 10, 32'h33, 0, 0);
    wb(1, 11, 32'h44, 0, 1);
    step();
    settle();
    chk("R8", "older retires", 32'(ret_cnt_o), 1);
    chk("R8", "exc behind", 32'(flush_exc_o), 1);
    step();
    settle();
    rd_chk("R8", 3, 32'h33);
    rd_chk("R8", 4, 32'h77);
    alloc_req(1, 0, 0, 0, 0);
    settle();
    chk("R8", "faulting idx reused", slot_idx(0), 11);
    step();
  endtask

  initial begin
    clr();
    arf_raddr_i = '0;
    repeat (3) @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    t_reset();
    step();
    t_alloc_basic();
    t_inorder();
    t_limit();
    t_wb_ignored();
    t_fill_stall();
    t_mispred();
    t_flush_drop();
    t_exception();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    #2000000;
    n_cmp++;
    n_mis++;
    $display("FAIL all-R watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

endmodule